// File: doc/BRIEF.md
# Register Write-Lock Controller

This block sits between a register interface and a register file. For every write request it decides, in the same cycle, whether the write may reach the register file. The decision draws on three lock sources. The first follows from the supervisor state: in ACTIVE and SAFE the state alone protects every lockable register. The second is a software lock flag, set and cleared by dedicated command strobes that take effect only in DIAGNOSTIC. The third is a configuration-lock flag that protects only the error-configuration register.

Registers outside the lockable set are never blocked. One example is the safety control register that holds the diagnostic exit and mask bits. Software cannot read back either lock flag. A blocked write is dropped without any error, and a debug pulse marks it.

Top module: `wr_lock_ctrl`

## Requirements
- R1: State codes are 3 bits: DIAGNOSTIC = 2, ACTIVE = 3, SAFE = 4, and any other value is a non-locking state (for example INIT = 1). In ACTIVE or SAFE, a write to any address whose bit is set in `LOCK_MASK` (default 0x00F1: addresses 0, 4, 5, 6 and 7) is blocked, whatever the lock flags hold.
- R2: A lock strobe in DIAGNOSTIC sets the software lock from the next cycle on. While that lock is set, writes to lockable addresses are blocked in every state. A write made in the same cycle as the strobe is still judged against the old flag value.
- R3: An unlock strobe in DIAGNOSTIC clears the software lock from the next cycle on. Lock and unlock strobes given in any other state have no effect.
- R4: When lock and unlock strobes arrive together in DIAGNOSTIC, the lock wins.
- R5: The software lock survives every change of state. Only reset or an unlock strobe in DIAGNOSTIC clears it.
- R6: If no lock strobe has been accepted, lockable writes are allowed in every state other than ACTIVE and SAFE. This includes the error-status register at address 4, which takes a full byte in one write.
- R7: Writes to addresses that are not lockable are always allowed. Address 2 (the safety control register) and address 3 are such addresses.
- R8: The config-lock register sits at address 6, and bit 0 of its data is the config-lock flag. A write to it is allowed only in DIAGNOSTIC while the software lock is clear. An allowed write loads the flag from bit 0.
- R9: While the config-lock flag is set, writes to the error-configuration register at address 5 are blocked. Other lockable registers, such as address 4, are not affected by this flag.
- R10: In a cycle with a write request, exactly one of `wr_allow_o` and `wr_block_o` is high, and both are combinational in that cycle. Without a request, both are low. A blocked write changes no lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| state_i | input | 3 | Supervisor state code |
| lock_cmd_i | input | 1 | Software lock command strobe |
| unlock_cmd_i | input | 1 | Software unlock command strobe |
| wr_en_i | input | 1 | Write request strobe |
| wr_addr_i | input | AW (4) | Write register address |
| wr_data_i | input | DW (8) | Write data |
| wr_allow_o | output | 1 | Write enable to the register file |
| wr_block_o | output | 1 | Debug pulse for a discarded write |

## Verification
The assertions assume that `state_i`, the command strobes and the write fields are free of X and stable around each rising edge. They also assume that the state code changes only on clock edges. The bench drives every input on the falling edge and keeps all inputs at known values, starting from reset. It samples the outputs one nanosecond later. Stimulus walks the state code through INIT, DIAGNOSTIC, ACTIVE and SAFE in a controlled order. This lets the persistence of the software lock, and the way commands are ignored outside DIAGNOSTIC, be observed through later write decisions.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
  typedef logic [2:0] fsm_code_t;
  localparam fsm_code_t ST_DIAG   = 3'd2;
  localparam fsm_code_t ST_ACTIVE = 3'd3;
  localparam fsm_code_t ST_SAFE   = 3'd4;

  function automatic logic state_locks(fsm_code_t s);
    return (s == ST_ACTIVE) || (s == ST_SAFE);
  endfunction
endpackage

// File: rtl/wlc_swlock.sv
module wlc_swlock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_diag_i,
  input  logic lock_i,
  input  logic unlock_i,
  output logic sw_lock_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      lock_q <= 1'b0;
    else if (in_diag_i && lock_i)     lock_q <= 1'b1;  // lock has priority
    else if (in_diag_i && unlock_i)   lock_q <= 1'b0;
  end

  assign sw_lock_o = lock_q;

  a_r4_lock_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_diag_i && lock_i && unlock_i) |=> lock_q);

  a_r3_cmds_outside_diag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_diag_i |=> $stable(lock_q));
endmodule

// File: rtl/wlc_cfglock.sv
module wlc_cfglock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic bit_i,
  output logic cfg_lock_o
);
  logic cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= 1'b0;
    else if (load_i) cfg_q <= bit_i;
  end

  assign cfg_lock_o = cfg_q;
endmodule

// File: rtl/wlc_decide.sv
module wlc_decide #(
  parameter int                  AW          = 4,
  parameter logic [(1<<AW)-1:0]  LOCK_MASK   = 16'h00F1,
  parameter logic [AW-1:0]       ERRCFG_ADDR = 4'h5,
  parameter logic [AW-1:0]       CFGLK_ADDR  = 4'h6
) (
  input  logic          state_lock_i,
  input  logic          in_diag_i,
  input  logic          sw_lock_i,
  input  logic          cfg_lock_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic          allow_o,
  output logic          block_o
);
  logic lockable_ok;
  logic permit;

  always_comb begin
    lockable_ok = !LOCK_MASK[wr_addr_i] || (!state_lock_i && !sw_lock_i);
    if (wr_addr_i == CFGLK_ADDR)
      permit = in_diag_i && !sw_lock_i;
    else
      permit = lockable_ok && !((wr_addr_i == ERRCFG_ADDR) && cfg_lock_i);
  end

  assign allow_o = wr_en_i && permit;
  assign block_o = wr_en_i && !permit;
endmodule

// File: rtl/wr_lock_ctrl.sv
module wr_lock_ctrl
  import wlc_pkg::*;
#(
  parameter int                  AW          = 4,
  parameter int                  DW          = 8,
  parameter logic [(1<<AW)-1:0]  LOCK_MASK   = 16'h00F1,
  parameter logic [AW-1:0]       ERRCFG_ADDR = 4'h5,
  parameter logic [AW-1:0]       CFGLK_ADDR  = 4'h6,
  parameter int                  CFGLK_BIT   = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    state_i,
  input  logic          lock_cmd_i,
  input  logic          unlock_cmd_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_allow_o,
  output logic          wr_block_o
);
  logic in_diag, state_lock, sw_lock, cfg_lock, cfg_load;

  assign in_diag    = (state_i == ST_DIAG);
  assign state_lock = state_locks(state_i);
  assign cfg_load   = wr_allow_o && (wr_addr_i == CFGLK_ADDR);

  wlc_swlock u_swlock (
    .clk_i, .rst_ni,
    .in_diag_i (in_diag),
    .lock_i    (lock_cmd_i),
    .unlock_i  (unlock_cmd_i),
    .sw_lock_o (sw_lock)
  );

  wlc_cfglock u_cfglock (
    .clk_i, .rst_ni,
    .load_i     (cfg_load),
    .bit_i      (wr_data_i[CFGLK_BIT]),
    .cfg_lock_o (cfg_lock)
  );

  wlc_decide #(
    .AW(AW), .LOCK_MASK(LOCK_MASK), .ERRCFG_ADDR(ERRCFG_ADDR), .CFGLK_ADDR(CFGLK_ADDR)
  ) u_decide (
    .state_lock_i (state_lock),
    .in_diag_i    (in_diag),
    .sw_lock_i    (sw_lock),
    .cfg_lock_i   (cfg_lock),
    .wr_en_i,
    .wr_addr_i,
    .allow_o      (wr_allow_o),
    .block_o      (wr_block_o)
  );

  a_r1_state_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (state_i == ST_ACTIVE || state_i == ST_SAFE) && LOCK_MASK[wr_addr_i])
      |-> !wr_allow_o);

  a_r7_unlockable_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !LOCK_MASK[wr_addr_i] && wr_addr_i != CFGLK_ADDR) |-> wr_allow_o);

  a_r10_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ($countones({wr_allow_o, wr_block_o}) == 1));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (!wr_allow_o && !wr_block_o));

  a_r8_cfg_guarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_diag && !sw_lock) |=> $stable(cfg_lock));
endmodule

// File: tb/wr_lock_ctrl_test.sv
`timescale 1ns/1ps
module wr_lock_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] state = 3'd1;
  logic       lk = 1'b0, ul = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] data = '0;
  logic       allow, block;

  int checks = 0, errors = 0;
  bit done = 0;
  // reference model state
  bit m_sw = 0, m_cfg = 0;

  always #2 clk = ~clk;

  wr_lock_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .state_i(state), .lock_cmd_i(lk), .unlock_cmd_i(ul),
    .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data), .wr_allow_o(allow), .wr_block_o(block)
  );

  function automatic bit lockable(int a);
    return (a == 0) || (a >= 4 && a <= 7);
  endfunction

  function automatic bit exp_ok(int s, int a);
    bit st_lk = (s == 3) || (s == 4);
    if (a == 6) return (s == 2) && !m_sw;
    if (a == 5 && m_cfg) return 0;
    if (lockable(a)) return !st_lk && !m_sw;
    return 1;
  endfunction

  task automatic check(string tag, bit ea, bit eb);
    checks++;
    if (allow !== ea || block !== eb) begin
      errors++;
      $display("FAIL %s: allow=%0b block=%0b expected allow=%0b block=%0b", tag, allow, block, ea, eb);
    end
  endtask

  task automatic st(int s, bit l, bit u, bit w, int a, int d, string tag);
    bit ok;
    @(negedge clk);
    state = 3'(s); lk = l; ul = u; we = w; addr = 4'(a); data = 8'(d);
    #1;
    ok = exp_ok(s, a);
    check(tag, w && ok, w && !ok);
    @(posedge clk);
    if (w && ok && a == 6) m_cfg = d[0];
    if (s == 2 && l) m_sw = 1;
    else if (s == 2 && u) m_sw = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R10 reset idle", 0, 0);
    rst_n = 1'b1;
    st(2, 0, 0, 1, 4, 8'hA5, "R6 diag errstat full byte");
    st(2, 0, 0, 1, 5, 8'h3C, "R6 diag errcfg");
    st(1, 0, 0, 1, 7, 8'h01, "R6 init lockable");
    st(2, 0, 0, 1, 6, 8'h01, "R8 set cfg lock");
    st(2, 0, 0, 1, 5, 8'h00, "R9 errcfg blocked");
    st(2, 0, 0, 1, 4, 8'hFF, "R9 errstat unaffected");
    st(2, 0, 0, 1, 6, 8'h00, "R8 clear cfg lock");
    st(2, 0, 0, 1, 5, 8'h11, "R8 errcfg reopened");
    st(3, 0, 0, 1, 4, 8'h00, "R1 active errstat");
    st(3, 0, 0, 1, 5, 8'h00, "R1 active errcfg");
    st(3, 0, 0, 1, 6, 8'h01, "R8 active cfglock write");
    st(3, 0, 0, 1, 2, 8'h01, "R7 active ctrl");
    st(4, 0, 0, 1, 7, 8'h00, "R1 safe lockable");
    st(4, 0, 0, 1, 0, 8'h00, "R1 safe addr0");
    st(3, 1, 0, 0, 0, 0,     "R3 lock in active");
    st(2, 0, 0, 1, 4, 8'h12, "R3 active lock ignored");
    st(2, 0, 0, 1, 5, 8'h12, "R10 blocked cfg write no effect");
    st(2, 1, 0, 1, 4, 8'h34, "R2 same-cycle old flag");
    st(2, 0, 0, 1, 4, 8'h34, "R2 locked errstat");
    st(2, 0, 0, 1, 6, 8'h01, "R8 cfglock under sw lock");
    st(2, 0, 0, 1, 2, 8'h01, "R7 ctrl under sw lock");
    st(2, 0, 0, 1, 3, 8'h01, "R7 free addr under sw lock");
    st(1, 0, 1, 0, 0, 0,     "R3 unlock in init");
    st(1, 0, 0, 1, 4, 8'h00, "R5 init still locked");
    st(3, 0, 0, 0, 0, 0,     "R5 to active");
    st(2, 0, 0, 1, 7, 8'h00, "R5 back in diag locked");
    st(2, 0, 1, 0, 0, 0,     "R3 unlock in diag");
    st(2, 0, 0, 1, 4, 8'h00, "R3 unlocked errstat");
    st(2, 0, 0, 1, 5, 8'h00, "R10 cfg flag untouched");
    st(2, 1, 1, 0, 0, 0,     "R4 both strobes");
    st(2, 0, 0, 1, 4, 8'h00, "R4 lock won");
    st(2, 0, 1, 0, 0, 0,     "R3 unlock again");
    st(1, 0, 0, 1, 0, 8'h00, "R6 init addr0 after unlock");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule